// File: doc/BRIEF.md
# Slot-Flag Queue Lock

This block is a hardware queue lock. It keeps one private flag per queue position. Each flag holds one of two values: wait or own. A requester that wants the lock raises its acquire line. In that same cycle the block hands it a place index, taken from a tail counter that wraps modulo the number of slots. From then on the requester watches only the flag at its own place, and it holds the lock while that flag reads own.

When the holder has finished, it presents a release with its place. In one clock edge the block does two things: it returns the holder's flag to wait, and it writes own into the flag of the next place. That next place is (place + 1) mod SLOTS. Ownership therefore moves strictly in the order in which places were handed out.

There are more requester ports (NREQ) than slots (SLOTS). When every slot is already taken by a queued or holding requester, an acquire is refused with a full indication.

Top module: `slotq_lock`

## Requirements
- R1: After reset, the flag at place 0 reads own, all other flags read wait, the tail counter is 0 and no grant is active. The first accepted requester therefore receives place 0.
- R2: An acquire from a requester that holds no place is accepted when a slot is free. In that same cycle `acq_ok` is high and `acq_place` carries the tail value. The tail then advances by one, modulo SLOTS.
- R3: Several acquires in one cycle are served in ascending requester index. They receive consecutive places starting at the tail, wrapping modulo SLOTS.
- R4: The number of requesters that hold a place never exceeds SLOTS. An acquire that finds no free slot gets `acq_full` high and `acq_ok` low, and no place is consumed. Within one cycle, the lower indices take the remaining free slots first.
- R5: `grant[i]` is high exactly when requester i holds a place whose flag reads own. At most one grant is high, and exactly one flag reads own at all times.
- R6: A release whose `rel_place` equals the place of the currently granted requester takes effect at the next edge. That requester's place is freed and its grant drops, its flag returns to wait, and the flag at (rel_place + 1) mod SLOTS becomes own.
- R7: A release whose place does not belong to the granted requester is ignored. Flags, grants and occupancy do not change.
- R8: An acquire from a requester that already holds a place is ignored. `acq_ok` and `acq_full` stay low and the tail does not move.
- R9: Ownership passes in FIFO order of place assignment, including across the wrap of the place index.
- R10: Free slots are counted from the occupancy at the start of the cycle. A release in the same cycle as an acquire makes its slot available only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_req | input | NREQ | Per-requester acquire request |
| acq_ok | output | NREQ | Acquire accepted this cycle |
| acq_full | output | NREQ | Acquire refused, no free slot |
| acq_place | output | NREQ*PW | Place assigned to each accepted requester, PW bits per requester, requester 0 in the low bits |
| grant | output | NREQ | Requester currently holds the lock |
| rel_valid | input | 1 | Release request |
| rel_place | input | PW | Place being released |

## Verification
The assertions assume two things about the inputs. First, `rel_place` always names an existing slot (below SLOTS). Second, reset is held for at least one edge before any request. Under those assumptions they rely on exactly one own flag and on releases by the holder being the only way the flags change. The stimulus never drives a place outside the slot range. It mixes holder releases, stray releases to other places and repeated acquires from enrolled requesters, so that both the accepted and the ignored paths are exercised.

// File: rtl/slotq_pkg.sv
// Shared types for the slot-flag queue lock.
// Assumes nothing beyond being compiled before the modules that import it.
package slotq_pkg;
    typedef enum logic {
        SLOT_WAIT = 1'b0,
        SLOT_OWN  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/slotq_alloc.sv
// Place allocator: the tail counter (fetch-and-increment modulo SLOTS) and the count of held places.
// Assumes elig_i excludes requesters that already hold a place, and free_i pulses once per accepted release.
module slotq_alloc #(
    parameter int SLOTS = 4,
    parameter int NREQ  = 6,
    localparam int PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
    localparam int CW   = $clog2(SLOTS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREQ-1:0]    elig_i,
    input  logic               free_i,
    output logic [NREQ-1:0]    take_o,
    output logic [NREQ-1:0]    refuse_o,
    output logic [NREQ*PW-1:0] place_o
);
    logic [PW-1:0] tail_q;
    logic [CW-1:0] used_q;
    logic [CW-1:0] taken_total;

    // Hand out consecutive places in ascending requester order while room remains.
    always_comb begin
        int taken;
        int room;
        taken = 0;
        room  = SLOTS - int'(used_q);
        for (int i = 0; i < NREQ; i++) begin
            take_o[i]             = 1'b0;
            refuse_o[i]           = 1'b0;
            place_o[i*PW +: PW]   = '0;
            if (elig_i[i]) begin
                if (taken < room) begin
                    take_o[i]           = 1'b1;
                    place_o[i*PW +: PW] = PW'((int'(tail_q) + taken) % SLOTS);
                    taken++;
                end else begin
                    refuse_o[i] = 1'b1;
                end
            end
        end
        taken_total = CW'(taken);
    end

    // Advance the tail and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q <= '0;
            used_q <= '0;
        end else begin
            tail_q <= PW'((int'(tail_q) + int'(taken_total)) % SLOTS);
            used_q <= used_q + taken_total - CW'(free_i);
        end
    end
endmodule

// File: rtl/slotq_slots.sv
// Per-place flag array: each place holds wait or own, and an accepted release moves own to the successor.
// Assumes rel_ok_i is only raised for the place whose flag currently reads own, and SLOTS >= 2.
module slotq_slots
    import slotq_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rel_ok_i,
    input  logic [PW-1:0]    rel_place_i,
    output logic [SLOTS-1:0] own_vec_o
);
    logic [PW-1:0] succ;

    // Successor place, wrapping modulo SLOTS.
    always_comb begin
        succ = (int'(rel_place_i) == SLOTS - 1) ? '0 : rel_place_i + 1'b1;
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        slot_state_e flag_q;

        // Place 0 starts as owner; on release, clear the releaser and set the successor.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= (k == 0) ? SLOT_OWN : SLOT_WAIT;
            end else if (rel_ok_i && rel_place_i == PW'(k)) begin
                flag_q <= SLOT_WAIT;
            end else if (rel_ok_i && succ == PW'(k)) begin
                flag_q <= SLOT_OWN;
            end
        end

        assign own_vec_o[k] = (flag_q == SLOT_OWN);
    end
endmodule

// File: rtl/slotq_track.sv
// One requester's record: whether it holds a place, which place, and its grant read from that place's flag.
// Assumes take_i is only raised while the requester holds no place.
module slotq_track #(
    parameter int SLOTS = 4,
    localparam int PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [PW-1:0]    place_i,
    input  logic             rel_ok_i,
    input  logic [PW-1:0]    rel_place_i,
    input  logic [SLOTS-1:0] own_vec_i,
    output logic             enrolled_o,
    output logic             grant_o,
    output logic             holds_rel_o
);
    logic [PW-1:0] place_q;

    // Enrol on an accepted acquire; leave on an accepted release of the own place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enrolled_o <= 1'b0;
            place_q    <= '0;
        end else if (take_i) begin
            enrolled_o <= 1'b1;
            place_q    <= place_i;
        end else if (rel_ok_i && enrolled_o && place_q == rel_place_i) begin
            enrolled_o <= 1'b0;
        end
    end

    // Grant follows the private flag; holds_rel marks a release aimed at this holder.
    always_comb begin
        grant_o     = enrolled_o && own_vec_i[place_q];
        holds_rel_o = grant_o && (place_q == rel_place_i);
    end
endmodule

// File: rtl/slotq_lock.sv
// Top of the slot-flag queue lock: allocator, flag array and one tracker per requester.
// Assumes rel_place is below SLOTS and reset is held for at least one edge.
module slotq_lock #(
    parameter int SLOTS = 4,
    parameter int NREQ  = 6,
    localparam int PW   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREQ-1:0]    acq_req,
    output logic [NREQ-1:0]    acq_ok,
    output logic [NREQ-1:0]    acq_full,
    output logic [NREQ*PW-1:0] acq_place,
    output logic [NREQ-1:0]    grant,
    input  logic               rel_valid,
    input  logic [PW-1:0]      rel_place
);
    logic [NREQ-1:0]  enrolled;
    logic [NREQ-1:0]  holds_rel;
    logic [NREQ-1:0]  elig;
    logic [SLOTS-1:0] own_vec;
    logic             rel_ok;

    // Only requesters without a place may take one; a release counts only from the holder.
    always_comb begin
        elig   = acq_req & ~enrolled;
        rel_ok = rel_valid && (|holds_rel);
    end

    slotq_alloc #(.SLOTS(SLOTS), .NREQ(NREQ)) u_alloc (
        .clk      (clk),
        .rst_n    (rst_n),
        .elig_i   (elig),
        .free_i   (rel_ok),
        .take_o   (acq_ok),
        .refuse_o (acq_full),
        .place_o  (acq_place)
    );

    slotq_slots #(.SLOTS(SLOTS)) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .rel_ok_i    (rel_ok),
        .rel_place_i (rel_place),
        .own_vec_o   (own_vec)
    );

    for (genvar i = 0; i < NREQ; i++) begin : g_req
        slotq_track #(.SLOTS(SLOTS)) u_track (
            .clk         (clk),
            .rst_n       (rst_n),
            .take_i      (acq_ok[i]),
            .place_i     (acq_place[i*PW +: PW]),
            .rel_ok_i    (rel_ok),
            .rel_place_i (rel_place),
            .own_vec_i   (own_vec),
            .enrolled_o  (enrolled[i]),
            .grant_o     (grant[i]),
            .holds_rel_o (holds_rel[i])
        );
    end
endmodule

// File: rtl/slotq_lock_chk.sv
// Property checker for slotq_lock, attached by bind below.
// Assumes rel_place stays below SLOTS.
module slotq_lock_chk #(
    parameter int SLOTS = 4,
    parameter int NREQ  = 6,
    parameter int PW    = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NREQ-1:0]  grant,
    input logic [NREQ-1:0]  enrolled,
    input logic [SLOTS-1:0] own_vec,
    input logic             rel_valid,
    input logic             rel_ok,
    input logic [PW-1:0]    rel_place
);
    function automatic logic [SLOTS-1:0] succ_hot(input logic [PW-1:0] p);
        succ_hot = '0;
        succ_hot[(int'(p) + 1) % SLOTS] = 1'b1;
    endfunction

    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(own_vec) == 1); // R5
    AST_MUTEX: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(enrolled) <= SLOTS); // R4
    AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
        rel_ok |=> (own_vec == succ_hot($past(rel_place)))); // R6
    AST_STRAY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_valid && !rel_ok) |=> $stable(own_vec)); // R7

    for (genvar i = 0; i < NREQ; i++) begin : g_hold
        AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && !rel_valid) |=> grant[i]); // R6
    end
endmodule

bind slotq_lock slotq_lock_chk #(.SLOTS(SLOTS), .NREQ(NREQ), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant     (grant),
    .enrolled  (enrolled),
    .own_vec   (own_vec),
    .rel_valid (rel_valid),
    .rel_ok    (rel_ok),
    .rel_place (rel_place)
);

// File: tb/slotq_lock_tb.sv
`timescale 1ns/100ps
// Bench for slotq_lock: behavioural reference model, compared on every cycle.
module slotq_lock_tb;
    localparam int SLOTS = 4;
    localparam int NREQ  = 6;
    localparam int PW    = 2;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NREQ-1:0]    acq_req = '0;
    logic [NREQ-1:0]    acq_ok;
    logic [NREQ-1:0]    acq_full;
    logic [NREQ*PW-1:0] acq_place;
    logic [NREQ-1:0]    grant;
    logic               rel_valid = 1'b0;
    logic [PW-1:0]      rel_place = '0;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit m_en [NREQ];
    int m_pl [NREQ];
    int m_tail, m_cnt, m_owner;

    always #2.5 clk = ~clk;

    slotq_lock #(.SLOTS(SLOTS), .NREQ(NREQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .acq_ok(acq_ok),
        .acq_full(acq_full), .acq_place(acq_place), .grant(grant),
        .rel_valid(rel_valid), .rel_place(rel_place)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, compare, then advance the model.
    task automatic step(input string tag, input logic [NREQ-1:0] a, input bit rv, input int rp);
        int room, taken, holder;
        bit relok;
        int newpl [NREQ];
        bit newen [NREQ];
        @(negedge clk);
        acq_req   = a;
        rel_valid = rv;
        rel_place = PW'(rp);
        #1;
        for (int i = 0; i < NREQ; i++) begin
            chk(tag, $sformatf("grant[%0d]", i), int'(grant[i]),
                int'(m_en[i] && m_pl[i] == m_owner));
        end
        room  = SLOTS - m_cnt;
        taken = 0;
        for (int i = 0; i < NREQ; i++) begin
            newen[i] = 1'b0;
            newpl[i] = 0;
            if (a[i] && !m_en[i]) begin
                if (taken < room) begin
                    newen[i] = 1'b1;
                    newpl[i] = (m_tail + taken) % SLOTS;
                    chk("R2", $sformatf("acq_ok[%0d]", i), int'(acq_ok[i]), 1);
                    chk((taken > 0) ? "R3" : "R2", $sformatf("acq_place[%0d]", i),
                        int'(acq_place[i*PW +: PW]), newpl[i]);
                    taken++;
                end else begin
                    chk("R4", $sformatf("acq_ok[%0d]", i), int'(acq_ok[i]), 0);
                    chk("R4", $sformatf("acq_full[%0d]", i), int'(acq_full[i]), 1);
                end
            end else begin
                chk("R8", $sformatf("acq_ok[%0d]", i), int'(acq_ok[i]), 0);
                chk("R8", $sformatf("acq_full[%0d]", i), int'(acq_full[i]), 0);
            end
        end
        holder = -1;
        for (int i = 0; i < NREQ; i++) if (m_en[i] && m_pl[i] == m_owner) holder = i;
        relok = rv && holder >= 0 && rp == m_owner;
        if (relok) begin
            m_en[holder] = 1'b0;
            m_owner      = (rp + 1) % SLOTS;
            m_cnt--;
        end
        for (int i = 0; i < NREQ; i++) begin
            if (newen[i]) begin
                m_en[i] = 1'b1;
                m_pl[i] = newpl[i];
            end
        end
        m_tail = (m_tail + taken) % SLOTS;
        m_cnt += taken;
    endtask

    function automatic int holder_place();
        holder_place = -1;
        for (int i = 0; i < NREQ; i++) if (m_en[i] && m_pl[i] == m_owner) holder_place = m_pl[i];
    endfunction

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREQ; i++) begin
            m_en[i] = 1'b0;
            m_pl[i] = 0;
        end
        m_tail = 0; m_cnt = 0; m_owner = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        step("R1", 6'b000000, 0, 0);          // R1 reset state, no grants
        step("R1", 6'b000001, 0, 0);          // R1 first acquirer gets place 0
        step("R1", 6'b001110, 0, 0);          // R3 three at once -> 1,2,3
        step("R4", 6'b110000, 0, 0);          // R4 table full
        step("R8", 6'b000011, 0, 0);          // R8 enrolled requesters re-acquire
        step("R7", 6'b000000, 1, 2);          // R7 stray release of place 2
        step("R7", 6'b000000, 1, 0);          // R6 holder releases place 0
        step("R10", 6'b110000, 1, 1);         // R10 release plus two acquires: one slot
        step("R6", 6'b000000, 0, 0);
        step("R9", 6'b000000, 1, 2);          // R9 FIFO through the wrap
        step("R9", 6'b000001, 1, 3);
        step("R9", 6'b000000, 1, 0);
        step("R9", 6'b000000, 1, 1);
        step("R9", 6'b000000, 0, 0);

        for (int n = 0; n < 3000; n++) begin
            logic [NREQ-1:0] a;
            int hp, r;
            a  = NREQ'($urandom) & NREQ'($urandom);
            hp = holder_place();
            r  = $urandom_range(0, 9);
            if (r < 4 && hp >= 0) step("R6", a, 1, hp);
            else if (r == 4) step("R7", a, 1, $urandom_range(0, SLOTS - 1));
            else step("R9", a, 0, 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule